// File: doc/BRIEF.md
# Clock Event Status and Interrupt Request

This block gathers the three event sources of a real-time clock into one status byte and drives a single active-high interrupt request. The sources are the end of a time update, a match between the current time and a programmed alarm time, and a periodic tick from a rate divider. The timekeeping counters and the divider are outside the block. The block receives the update-done pulse along with the current seconds, minutes and hours, the three alarm bytes, the periodic pulse, the control byte and a read strobe for the status byte.

A flag is recorded whenever its event occurs, whether or not that event's enable bit is set. Only enabled flags contribute to the summary bit and to the request line. Software reads the status byte to find the cause, and the read clears it. An event that arrives in the same cycle as a read is not lost. While the control byte's set bit is high, updates are frozen, so neither update nor alarm flags can appear.

Top module: `rtc_evt_stat`

## Requirements
- R1: After reset the status byte reads 0x00 and the request output is low.
- R2: An update-done pulse while control bit 7 is low sets status bit 4 in the next cycle.
- R3: On an update-done pulse while control bit 7 is low, status bit 5 is set in the next cycle only when the seconds, minutes and hours all match their alarm bytes. A single mismatched field leaves bit 5 clear.
- R4: An alarm byte whose bits 7 and 6 are both 1 matches any current value of its field. An alarm byte that has only one of those two bits set is compared literally.
- R5: A periodic pulse sets status bit 6 in the next cycle, whatever the value of control bit 7.
- R6: While control bit 7 is high, update-done pulses set neither status bit 4 nor status bit 5.
- R7: Flags are recorded even when their enables (control bits 4, 5, 6 for update, alarm, periodic) are clear. Status bits 3:0 always read 0.
- R8: Status bit 7 is 1 exactly when some status bit n in 4..6 and control bit n are both 1. The request output always equals status bit 7.
- R9: A read strobe returns the current status in that cycle and clears bits 6:4 at the next edge. A flag whose event arrives in the same cycle as the read is set after that edge.
- R10: A flag stays set across idle cycles until a read strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_b | input | 8 | Control byte: bit 7 freezes updates, bits 6:4 enable periodic, alarm and update requests |
| upd_done | input | 1 | One-cycle pulse at the end of a time update |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds, 0xC0-0xFF means any |
| alm_min | input | 8 | Alarm minutes, 0xC0-0xFF means any |
| alm_hr | input | 8 | Alarm hours, 0xC0-0xFF means any |
| per_tick | input | 1 | One-cycle periodic pulse |
| stat_rd | input | 1 | Status read strobe; clears flags at the next edge |
| stat_c | output | 8 | Status byte |
| irq | output | 1 | Active-high interrupt request |

## Verification
The first sweep covers every combination of the three enables with every combination of the three events. It separates flag recording, which ignores enables, from request generation, which depends on them. The second sweep takes each alarm field as matching, mismatching or wildcard in all 27 combinations. This exposes a field that is skipped in the compare, a wrong wildcard decode, and byte values with only one of the two top bits set. Further directed sequences hold the set bit high during updates, place events in the same cycle as a read, and idle with flags pending. These cases separate clearing from capturing and show that flags persist.

// File: rtl/rtc_evt_stat.sv
module rtc_evt_stat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   ctl_b,
  input  logic         upd_done,
  input  logic [W-1:0] cur_sec,
  input  logic [W-1:0] cur_min,
  input  logic [W-1:0] cur_hr,
  input  logic [W-1:0] alm_sec,
  input  logic [W-1:0] alm_min,
  input  logic [W-1:0] alm_hr,
  input  logic         per_tick,
  input  logic         stat_rd,
  output logic [7:0]   stat_c,
  output logic         irq
);
  logic [2:0] flg_q, flg_d, evt;
  logic       upd_ok, hit_s, hit_m, hit_h;

  function automatic logic fld_hit(input logic [W-1:0] alm, input logic [W-1:0] cur);
    return (alm[W-1:W-2] == 2'b11) || (alm == cur);
  endfunction

  assign upd_ok = upd_done && !ctl_b[7];
  assign hit_s  = fld_hit(alm_sec, cur_sec);
  assign hit_m  = fld_hit(alm_min, cur_min);
  assign hit_h  = fld_hit(alm_hr,  cur_hr);

  assign evt   = {per_tick, upd_ok && hit_s && hit_m && hit_h, upd_ok};
  assign flg_d = (stat_rd ? 3'b000 : flg_q) | evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;

  assign stat_c = {|(flg_q & ctl_b[6:4]), flg_q, 4'h0};
  assign irq    = stat_c[7];
endmodule

module rtc_evt_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_b,
  input logic       upd_done,
  input logic       per_tick,
  input logic       stat_rd,
  input logic [7:0] stat_c,
  input logic       irq
);
  AST_LOW_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) stat_c[3:0] == 4'h0); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) irq == |(stat_c[6:4] & ctl_b[6:4])); // R8
  AST_UPD_SET:   assert property (@(posedge clk) disable iff (!rst_n) (upd_done && !ctl_b[7]) |=> stat_c[4]); // R2
  AST_PER_SET:   assert property (@(posedge clk) disable iff (!rst_n) per_tick |=> stat_c[6]); // R5
  AST_FROZEN:    assert property (@(posedge clk) disable iff (!rst_n)
                   (!stat_c[4] && !stat_c[5] && !(upd_done && !ctl_b[7])) |=> (!stat_c[4] && !stat_c[5])); // R6
  AST_RD_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n)
                   (stat_rd && !upd_done && !per_tick) |=> stat_c[6:4] == 3'b000); // R9
  AST_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) (stat_c[6] && !stat_rd) |=> stat_c[6]); // R10
endmodule

bind rtc_evt_stat rtc_evt_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_b(ctl_b), .upd_done(upd_done),
  .per_tick(per_tick), .stat_rd(stat_rd), .stat_c(stat_c), .irq(irq)
);

// File: tb/rtc_evt_stat_bench.sv
module rtc_evt_stat_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] ctl_b = 0, cur_sec = 0, cur_min = 0, cur_hr = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
  logic upd_done = 0, per_tick = 0, stat_rd = 0;
  logic [7:0] stat_c;
  logic irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  rtc_evt_stat u_rtc_evt_stat (
    .clk(clk), .rst_n(rst_n), .ctl_b(ctl_b), .upd_done(upd_done),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .per_tick(per_tick), .stat_rd(stat_rd), .stat_c(stat_c), .irq(irq)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expect_c(input logic [2:0] f, input logic [7:0] b);
    return {|(f & b[6:4]), f, 4'h0};
  endfunction

  task automatic clear_all();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic fire(input logic u, input logic p);
    upd_done = u; per_tick = p; @(negedge clk); upd_done = 0; per_tick = 0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(stat_c, 8'h00, "R1 status");
    chk({7'd0, irq}, 8'h00, "R1 irq");
    rst_n = 1;
    @(negedge clk);

    cur_sec = 8'h30; cur_min = 8'h15; cur_hr = 8'h09;
    for (int en = 0; en < 8; en++) begin
      for (int e = 0; e < 8; e++) begin
        logic [2:0] f;
        ctl_b = {1'b0, en[2:0], 4'h0};
        alm_sec = e[1] ? 8'h30 : 8'h31; alm_min = 8'h15; alm_hr = 8'h09;
        clear_all();
        fire(e[0] | e[1], e[2]);
        f = {e[2], e[1], e[0] | e[1]};
        chk(stat_c, expect_c(f, ctl_b), "R7 R2 R3 R5 sweep");
        chk({7'd0, irq}, {7'd0, |(f & en[2:0])}, "R8 irq");
      end
    end

    ctl_b = 8'h20;
    for (int s = 0; s < 3; s++)
      for (int m = 0; m < 3; m++)
        for (int h = 0; h < 3; h++) begin
          logic [7:0] wc [3];
          logic hit;
          wc[0] = 8'hC0; wc[1] = 8'hFF; wc[2] = 8'hD5;
          alm_sec = (s == 0) ? 8'h30 : (s == 1) ? 8'h80 : wc[(s+m+h) % 3];
          alm_min = (m == 0) ? 8'h15 : (m == 1) ? 8'h40 : wc[(m+h) % 3];
          alm_hr  = (h == 0) ? 8'h09 : (h == 1) ? 8'h49 : wc[h % 3];
          hit = (s != 1) && (m != 1) && (h != 1);
          clear_all();
          fire(1, 0);
          chk(stat_c, expect_c({1'b0, hit, 1'b1}, ctl_b), "R3 R4 alarm sweep");
        end

    alm_sec = 8'h30; alm_min = 8'h15; alm_hr = 8'h09;
    ctl_b = 8'hF0;
    clear_all();
    fire(1, 0);
    chk(stat_c, 8'h00, "R6 frozen update");
    fire(1, 1);
    chk(stat_c, 8'hC0, "R6 R5 periodic while frozen");

    ctl_b = 8'h70;
    clear_all();
    fire(1, 1);
    chk(stat_c, 8'hF0, "R10 all set");
    repeat (5) @(negedge clk);
    chk(stat_c, 8'hF0, "R10 held");
    stat_rd = 1;
    #1 chk(stat_c, 8'hF0, "R9 read value");
    @(negedge clk); stat_rd = 0;
    chk(stat_c, 8'h00, "R9 cleared");
    fire(1, 0);
    stat_rd = 1; per_tick = 1;
    @(negedge clk); stat_rd = 0; per_tick = 0;
    chk(stat_c, 8'hC0, "R9 coincident event kept");
    ctl_b = 8'h00;
    #1 chk({7'd0, irq}, 8'h00, "R8 disabled irq low");
    chk(stat_c, 8'h40, "R7 flag without enable");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule